// File: doc/BRIEF.md
# Shared Timebase Counter with Per-Core Compare Interrupts

The block keeps one free-running counter that all cores share. Its width is set at build time to 32 plus four times a selector, so it can be anywhere from 32 to 64 bits wide. Software reaches the counter over a simple 32-bit register bus. The counter appears as a lower half and an upper half, and either half can be read or written. A stop flag in the configuration word freezes the count. The same word reports the width selector, so software can work out how many bits the counter has.

Each core has its own 64-bit compare value, also split into two 32-bit halves. Once the shared count reaches or passes a core's compare value, that core's timer interrupt goes high and stays high. Software clears it by writing either half of that core's compare value. The hardware does not make a 64-bit read atomic. Software reads the upper half, then the lower half, then the upper half again, and retries if the two upper reads differ. For that scheme to work, a carry out of the lower half must reach the upper half on the same clock edge.

Top module: `timebase_cmp`

## Requirements
- R1: After reset the stop flag is 0 and the counter advances by exactly one on every clock edge on which no counter half is written.
- R2: Address 0 is the configuration word. Bit 0 is the stop flag. While the flag is 1 the counter holds its value, and clearing the flag lets counting resume from that held value.
- R3: Address 1 holds counter bits 31:0 and address 2 holds counter bits 63:32. A write to either address loads only that half.
- R4: When the lower half goes from all ones to zero, the upper half increments on the same clock edge.
- R5: The counter is 32+4*WIDTH_SEL bits wide, and configuration bits 11:8 read back WIDTH_SEL. Counter bits above that width read as zero, and the counter wraps to zero after its all-ones value.
- R6: Core c has compare bits 31:0 at address 4+2c and bits 63:32 at address 5+2c. Both halves read back what was written, and both reset to all ones.
- R7: A core's interrupt is set on the clock edge after the counter becomes greater than or equal to that core's compare value. It then stays set until it is cleared.
- R8: Writing either compare half of a core clears that core's interrupt on the same edge, and leaves the other cores' interrupts unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | ADDR_W | Register word address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, combinational on addr_i |
| timer_irq_o | output | NUM_CORES | Per-core timer compare interrupt |

## Verification
Some properties are checked by assertions on every cycle. One is the single-step advance of a running counter; another is that a stopped counter holds its value. The carry from the lower half into the upper half within one edge is also checked this way, and so is the rule that unimplemented upper bits read as zero. The set and clear rules of each compare interrupt are checked in the same way. Other behaviour is only shown by the bench's scenarios: the readback of the configuration and compare registers, and the exact counts after a measured run. The same holds for wraparound at the implemented width, re-arming the interrupt after a clear, and the independence of one core's interrupt from writes to another core's compare value.

// File: rtl/timebase_pkg.sv
package timebase_pkg;
  localparam int unsigned ADDR_CFG      = 0;
  localparam int unsigned ADDR_CNT_LO   = 1;
  localparam int unsigned ADDR_CNT_HI   = 2;
  localparam int unsigned ADDR_CMP_BASE = 4;
  localparam int unsigned CFG_STOP_BIT  = 0;
  localparam int unsigned CFG_WSEL_LSB  = 8;
  localparam int unsigned CFG_WSEL_W    = 4;
endpackage

// File: rtl/timebase_counter.sv
module timebase_counter #(
  parameter int unsigned CNT_W = 48
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        stop_i,
  input  logic        wr_lo_i,
  input  logic        wr_hi_i,
  input  logic [31:0] wdata_i,
  output logic [63:0] cnt_o
);
  localparam logic [63:0] CNT_MASK = (CNT_W >= 64) ? {64{1'b1}} : ((64'd1 << CNT_W) - 64'd1);
  localparam logic [31:0] HI_MASK  = CNT_MASK[63:32];

  logic [CNT_W-1:0] cnt_q;
  logic [63:0]      load_val;
  logic             run;

  assign cnt_o    = 64'(cnt_q);
  assign run      = !stop_i && !wr_lo_i && !wr_hi_i;
  assign load_val = wr_hi_i ? {wdata_i, cnt_o[31:0]} : {cnt_o[63:32], wdata_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (wr_lo_i || wr_hi_i) cnt_q <= load_val[CNT_W-1:0];
    else if (!stop_i)           cnt_q <= cnt_q + CNT_W'(1);
  end

  assert_count_step_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run |=> cnt_o == ((($past(cnt_o)) + 64'd1) & CNT_MASK));

  assert_stop_holds_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_i && !wr_lo_i && !wr_hi_i) |=> $stable(cnt_o));

  assert_low_carry_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run && cnt_o[31:0] == 32'hFFFF_FFFF) |=>
      (cnt_o[31:0] == 32'd0) && (cnt_o[63:32] == (($past(cnt_o[63:32]) + 32'd1) & HI_MASK)));
endmodule

// File: rtl/timebase_cmp_unit.sv
module timebase_cmp_unit (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_lo_i,
  input  logic        wr_hi_i,
  input  logic [31:0] wdata_i,
  input  logic [63:0] cnt_i,
  output logic [63:0] cmp_o,
  output logic        irq_o
);
  logic [63:0] cmp_q;
  logic        irq_q;
  logic        wr_any;

  assign wr_any = wr_lo_i || wr_hi_i;
  assign cmp_o  = cmp_q;
  assign irq_o  = irq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmp_q <= '1;
    end else begin
      if (wr_lo_i) cmp_q[31:0]  <= wdata_i;
      if (wr_hi_i) cmp_q[63:32] <= wdata_i;
    end
  end

  // sticky once reached; any compare write acknowledges
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                irq_q <= 1'b0;
    else if (wr_any)            irq_q <= 1'b0;
    else if (cnt_i >= cmp_q)    irq_q <= 1'b1;
  end

  assert_irq_set_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_any && cnt_i >= cmp_o) |=> irq_o);

  assert_irq_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_any && irq_o) |=> irq_o);

  assert_irq_clear_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_any |=> !irq_o);
endmodule

// File: rtl/timebase_cmp.sv
module timebase_cmp
  import timebase_pkg::*;
#(
  parameter int unsigned NUM_CORES = 2,
  parameter int unsigned WIDTH_SEL = 4,
  parameter int unsigned ADDR_W    = 4
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 wr_en_i,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic [31:0]          wdata_i,
  output logic [31:0]          rdata_o,
  output logic [NUM_CORES-1:0] timer_irq_o
);
  localparam int unsigned CNT_W = 32 + 4 * WIDTH_SEL;
  localparam logic [63:0] CNT_MASK = (CNT_W >= 64) ? {64{1'b1}} : ((64'd1 << CNT_W) - 64'd1);
  localparam logic [31:0] HI_MASK  = CNT_MASK[63:32];

  logic        stop_q;
  logic [63:0] cnt;
  logic [63:0] cmp_val [NUM_CORES];
  logic        wr_cfg, wr_cnt_lo, wr_cnt_hi;

  assign wr_cfg    = wr_en_i && (addr_i == ADDR_W'(ADDR_CFG));
  assign wr_cnt_lo = wr_en_i && (addr_i == ADDR_W'(ADDR_CNT_LO));
  assign wr_cnt_hi = wr_en_i && (addr_i == ADDR_W'(ADDR_CNT_HI));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     stop_q <= 1'b0;
    else if (wr_cfg) stop_q <= wdata_i[CFG_STOP_BIT];
  end

  timebase_counter #(.CNT_W(CNT_W)) u_counter (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .stop_i  (stop_q),
    .wr_lo_i (wr_cnt_lo),
    .wr_hi_i (wr_cnt_hi),
    .wdata_i (wdata_i),
    .cnt_o   (cnt)
  );

  for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
    logic wr_lo, wr_hi;
    assign wr_lo = wr_en_i && (addr_i == ADDR_W'(ADDR_CMP_BASE + 2 * c));
    assign wr_hi = wr_en_i && (addr_i == ADDR_W'(ADDR_CMP_BASE + 2 * c + 1));

    timebase_cmp_unit u_cmp (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .wr_lo_i (wr_lo),
      .wr_hi_i (wr_hi),
      .wdata_i (wdata_i),
      .cnt_i   (cnt),
      .cmp_o   (cmp_val[c]),
      .irq_o   (timer_irq_o[c])
    );
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i == ADDR_W'(ADDR_CFG)) begin
      rdata_o[CFG_STOP_BIT] = stop_q;
      rdata_o[CFG_WSEL_LSB +: CFG_WSEL_W] = CFG_WSEL_W'(WIDTH_SEL);
    end
    if (addr_i == ADDR_W'(ADDR_CNT_LO)) rdata_o = cnt[31:0];
    if (addr_i == ADDR_W'(ADDR_CNT_HI)) rdata_o = cnt[63:32];
    for (int c = 0; c < NUM_CORES; c++) begin
      if (addr_i == ADDR_W'(ADDR_CMP_BASE + 2 * c))     rdata_o = cmp_val[c][31:0];
      if (addr_i == ADDR_W'(ADDR_CMP_BASE + 2 * c + 1)) rdata_o = cmp_val[c][63:32];
    end
  end

  assert_hi_unimpl_zero_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == ADDR_W'(ADDR_CNT_HI)) |-> ((rdata_o & ~HI_MASK) == 32'd0));
endmodule

// File: tb/timebase_cmp_tb.sv
module timebase_cmp_tb;
  localparam int ADDR_W = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [1:0]  irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  timebase_cmp #(.NUM_CORES(2), .WIDTH_SEL(4), .ADDR_W(ADDR_W)) u_dut (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .wr_en_i     (wr_en),
    .addr_i      (addr),
    .wdata_i     (wdata),
    .rdata_o     (rdata),
    .timer_irq_o (irq)
  );

  // lo_start, hi_start, run_cycles, exp_lo, exp_hi (48-bit counter)
  localparam logic [31:0] VEC [5][5] = '{
    '{32'h0000_0000, 32'h0000_0000, 32'd5, 32'h0000_0005, 32'h0000_0000},
    '{32'hFFFF_FFFE, 32'h0000_0000, 32'd3, 32'h0000_0001, 32'h0000_0001},
    '{32'hFFFF_FFFF, 32'h0000_1234, 32'd1, 32'h0000_0000, 32'h0000_1235},
    '{32'hFFFF_FFFF, 32'h0000_FFFF, 32'd1, 32'h0000_0000, 32'h0000_0000},
    '{32'h0000_0010, 32'hFFFF_FFFF, 32'd2, 32'h0000_0012, 32'h0000_FFFF}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // caller sits just after a negedge; write commits on the next posedge
  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  // exactly n increments, counter stopped afterwards
  task automatic run(input int n);
    wr(4'd0, 32'd0);
    repeat (n - 1) @(negedge clk);
    wr(4'd0, 32'd1);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, v2;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // reset state
    rd(4'd0, v); check("R1 R5 cfg after reset", v, 32'h0000_0400);
    rd(4'd4, v); check("R6 core0 cmp lo reset", v, 32'hFFFF_FFFF);
    rd(4'd7, v); check("R6 core1 cmp hi reset", v, 32'hFFFF_FFFF);
    check("R7 irq after reset", {30'd0, irq}, 32'd0);

    // runs freely after reset
    rd(4'd1, v);
    repeat (5) @(negedge clk);
    rd(4'd1, v2);
    check("R1 free run step", v2 - v, 32'd5);

    // vector table
    for (int i = 0; i < 5; i++) begin
      wr(4'd0, 32'd1);
      wr(4'd1, VEC[i][0]);
      wr(4'd2, VEC[i][1]);
      run(int'(VEC[i][2]));
      rd(4'd1, v); check($sformatf("R3 R4 vec%0d lo", i), v, VEC[i][3]);
      rd(4'd2, v); check($sformatf("R4 R5 vec%0d hi", i), v, VEC[i][4]);
    end

    // stop holds, clear resumes
    wr(4'd0, 32'd1);
    rd(4'd0, v); check("R2 stop readback", v, 32'h0000_0401);
    wr(4'd1, 32'd1000);
    wr(4'd2, 32'd0);
    repeat (10) @(negedge clk);
    rd(4'd1, v); check("R2 frozen", v, 32'd1000);
    wr(4'd0, 32'd0);
    repeat (3) @(negedge clk);
    wr(4'd0, 32'd1);
    rd(4'd1, v); check("R2 resume", v, 32'd1004);

    // compare interrupt
    wr(4'd1, 32'd100);
    wr(4'd5, 32'd0);
    wr(4'd4, 32'd105);
    check("R7 below compare", {31'd0, irq[0]}, 32'd0);
    run(5);
    rd(4'd1, v); check("R7 count at compare", v, 32'd105);
    check("R7 not yet set", {31'd0, irq[0]}, 32'd0);
    @(negedge clk);
    check("R7 set one edge later", {31'd0, irq[0]}, 32'd1);
    check("R7 core1 idle", {31'd0, irq[1]}, 32'd0);
    repeat (4) @(negedge clk);
    check("R7 stays set", {31'd0, irq[0]}, 32'd1);
    wr(4'd6, 32'd200);
    wr(4'd7, 32'd0);
    check("R8 other core write keeps irq0", {31'd0, irq[0]}, 32'd1);
    check("R8 core1 below compare", {31'd0, irq[1]}, 32'd0);
    wr(4'd5, 32'd1);
    check("R8 cleared on hi write", {31'd0, irq[0]}, 32'd0);
    repeat (2) @(negedge clk);
    check("R8 stays clear", {31'd0, irq[0]}, 32'd0);
    rd(4'd5, v); check("R6 core0 hi readback", v, 32'd1);
    rd(4'd4, v); check("R6 core0 lo readback", v, 32'd105);
    rd(4'd6, v); check("R6 core1 lo readback", v, 32'd200);
    wr(4'd5, 32'd0);
    check("R8 clear on rearm write", {31'd0, irq[0]}, 32'd0);
    @(negedge clk);
    check("R7 rearm sets", {31'd0, irq[0]}, 32'd1);
    wr(4'd4, 32'd105);
    check("R8 cleared on lo write", {31'd0, irq[0]}, 32'd0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule